// File: doc/BRIEF.md
# Dual-Enable Separate-I/O Static Memory

This block is a clocked model of a 16384-word by 4-bit static memory. It has one write data bus, one read data bus, two active-low select inputs and an active-low write strobe. All control inputs are sampled on the system clock. A write is open while both selects and the write strobe are low. It commits on the clock edge that first samples the overlap as ended, using the address and data seen on the last sample inside the overlap. A write can be closed by the write strobe or by either select, whichever rises first.

The output bus is paired with a drive-enable flag that stands in for a three-state driver. A parameter picks the output behaviour during a write. In the pass-through variant, the output shows the incoming data. In the blanked variant, the output is not driven. Inside, the array is laid out as 256 rows of 64 words, and the address bits are spread across row and column selects. A sleep flag reports, one clock later, that the block is deselected.

Top module: `sepio_sram`

## Requirements
- R1: A write happens only when `cs_a_n`, `cs_b_n` and `wr_n` are all sampled low. It commits on the first edge where that overlap is no longer sampled, storing `din` at `addr` as sampled on the last edge of the overlap. A later read returns that word.
- R2: The write is closed by whichever of `wr_n`, `cs_a_n` or `cs_b_n` rises first. Each of the three closes and commits a write in the same way.
- R3: If `wr_n` is low while either select is high, no write takes place. A later read of that address returns the earlier contents.
- R4: An edge that samples both selects low and `wr_n` high drives `dout_en` = 1 after that edge, with `dout` holding the word at the sampled address.
- R5: An edge that samples either select high drives `dout_en` = 0 after that edge, in both variants.
- R6: With `TRANSPARENT` = 0, an edge that samples `wr_n` low drives `dout_en` = 0 after it. When a select and `wr_n` rise on the same sample, `dout_en` stays 0.
- R7: With `TRANSPARENT` = 1, an edge that samples an open write drives `dout_en` = 1 and `dout` equal to the `din` sampled on that edge.
- R8: A read sampled on the same edge that commits a write to the same address returns the newly written word.
- R9: `sleep` is 1 after any edge that samples either select high, and 0 after an edge that samples both selects low.
- R10: Every one of the 16384 addresses reaches its own word. Changing any single address bit selects a different word.
- R11: Synchronous active-high `rst` sets `dout_en` = 0 and `sleep` = 1 and cancels any open write. Memory contents are left undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, all inputs sampled on its rising edge |
| rst | input | 1 | synchronous active-high reset |
| addr | input | 14 | word address |
| din | input | 4 | write data |
| cs_a_n | input | 1 | first select, active low |
| cs_b_n | input | 1 | second select, active low |
| wr_n | input | 1 | write strobe, active low |
| dout | output | 4 | read data, meaningful only while `dout_en` is 1 |
| dout_en | output | 1 | output drive enable, stands in for three-state drive |
| sleep | output | 1 | deselected / power-down indication |

## Verification
Every result is due exactly one clock edge after the sample that causes it. This applies to `dout`, `dout_en` and `sleep`, and to a write commit, which is visible to a read sampled on the closing edge itself. The bench changes inputs on the falling edge and checks 2 ns after the next rising edge. It updates its reference model in the same step, committing a finished write before it works out the read for that sample. Data is compared only for addresses the bench has already written. Both output variants run side by side on the same stimulus.

// File: rtl/sepio_sram_pkg.sv
package sepio_sram_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 4;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 6;

  typedef enum logic {
    SRC_MEM  = 1'b0,
    SRC_HOLD = 1'b1
  } out_src_e;
endpackage

// File: rtl/sepio_addr_map.sv
// Scatters the logical address over the physical row/column select lines.
module sepio_addr_map
  import sepio_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = ROW_W,
  parameter int CW = COL_W
) (
  input  logic [AW-1:0] log_addr,
  output logic [AW-1:0] phys_addr
);
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  // row select: eight contiguous logical bits starting at bit 2
  genvar gi;
  generate
    for (gi = 0; gi < RW; gi++) begin : g_row
      assign row[gi] = log_addr[gi+2];
    end
  endgenerate

  // column select order
  assign col[0] = log_addr[10];
  assign col[1] = log_addr[11];
  assign col[2] = log_addr[1];
  assign col[3] = log_addr[0];
  assign col[4] = log_addr[13];
  assign col[5] = log_addr[12];

  assign phys_addr = {row, col};

  // R10: the map is a bijection, so two logical addresses differing in one bit never collide
  always_comb begin
    assert ($countones(phys_addr) == $countones(log_addr))
      else $error("p_map_weight_r10");
  end
endmodule

// File: rtl/sepio_array.sv
// Storage: one write port, one registered read port, no reset on contents.
module sepio_array
  import sepio_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sepio_ctrl.sv
// Samples controls, detects the end of the write overlap, drives flags.
module sepio_ctrl
  import sepio_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic          wr_n,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_go,
  output out_src_e      src_q,
  output logic [DW-1:0] hold_q,
  output logic          en_q,
  output logic          sleep_q
);
  logic          sel;
  logic          wa;
  logic          act_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] din_q;

  assign sel     = ~cs_a_n & ~cs_b_n;
  assign wa      = sel & ~wr_n;
  assign rd_go   = sel & wr_n;
  assign wr_go   = act_q & ~wa;
  assign wr_addr = adr_q;
  assign wr_data = din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      adr_q   <= '0;
      din_q   <= '0;
      en_q    <= 1'b0;
      sleep_q <= 1'b1;
      src_q   <= SRC_MEM;
      hold_q  <= '0;
    end else begin
      act_q   <= wa;
      adr_q   <= addr;
      din_q   <= din;
      sleep_q <= ~sel;
      en_q    <= sel & (TRANSPARENT | wr_n);
      if (wa && TRANSPARENT) begin
        src_q  <= SRC_HOLD;
        hold_q <= din;
      end else if (rd_go) begin
        if (wr_go && (adr_q == addr)) begin
          src_q  <= SRC_HOLD;
          hold_q <= din_q;
        end else begin
          src_q  <= SRC_MEM;
        end
      end
    end
  end

  p_commit_src_r1: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> $past(!cs_a_n && !cs_b_n && !wr_n));

  p_desel_off_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_a_n || cs_b_n) |=> !en_q);

  p_sleep_set_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_a_n || cs_b_n) |=> sleep_q);

  p_sleep_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (!cs_a_n && !cs_b_n) |=> !sleep_q);

  generate
    if (TRANSPARENT) begin : g_tr_chk
      p_pass_data_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_a_n && !cs_b_n && !wr_n) |=> (en_q && hold_q == $past(din)));
    end else begin : g_bl_chk
      p_blank_wr_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> !en_q);
    end
  endgenerate
endmodule

// File: rtl/sepio_sram.sv
module sepio_sram
  import sepio_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic          wr_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          sleep
);
  logic          wr_go;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_go;
  out_src_e      src_q;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] w_phys;
  logic [AW-1:0] r_phys;
  logic [DW-1:0] rdata;

  sepio_ctrl #(.AW(AW), .DW(DW), .TRANSPARENT(TRANSPARENT)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .rd_go(rd_go),
    .src_q(src_q), .hold_q(hold_q), .en_q(dout_en), .sleep_q(sleep)
  );

  sepio_addr_map #(.AW(AW)) u_map_w (.log_addr(wr_addr), .phys_addr(w_phys));
  sepio_addr_map #(.AW(AW)) u_map_r (.log_addr(addr),    .phys_addr(r_phys));

  sepio_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(wr_go), .waddr(w_phys), .wdata(wr_data),
    .re(rd_go), .raddr(r_phys), .rdata(rdata)
  );

  assign dout = (src_q == SRC_MEM) ? rdata : hold_q;
endmodule

// File: tb/tb_sepio_sram.sv
`timescale 1ns/1ps
module tb_sepio_sram;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] addr;
  logic [3:0]  din;
  logic        cs_a_n, cs_b_n, wr_n;
  logic [3:0]  dout_t, dout_b;
  logic        en_t, en_b, slp_t, slp_b;

  int checks = 0;
  int errs   = 0;
  logic [3:0] bmem [int];
  logic        p_wa;
  logic [13:0] p_addr;
  logic [3:0]  p_din;
  logic [13:0] pool [8];

  always #10 clk = ~clk;

  sepio_sram #(.TRANSPARENT(1'b1)) dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .cs_a_n(cs_a_n),
    .cs_b_n(cs_b_n), .wr_n(wr_n), .dout(dout_t), .dout_en(en_t), .sleep(slp_t));

  sepio_sram #(.TRANSPARENT(1'b0)) dut_b (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .cs_a_n(cs_a_n),
    .cs_b_n(cs_b_n), .wr_n(wr_n), .dout(dout_b), .dout_en(en_b), .sleep(slp_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one sampled cycle: drive on falling edge, check just after the rising edge
  task automatic step(input bit a, input bit b, input bit w,
                      input logic [13:0] ad, input logic [3:0] d);
    bit sel, wa, byp;
    string rq;
    @(negedge clk);
    cs_a_n = a; cs_b_n = b; wr_n = w; addr = ad; din = d;
    @(posedge clk);
    #2;
    sel = !a && !b;
    wa  = sel && !w;
    byp = p_wa && !wa && (p_addr == ad);
    if (p_wa && !wa) bmem[int'(p_addr)] = p_din;   // R1/R2 commit model
    p_wa = wa; p_addr = ad; p_din = d;
    chk(slp_t == !sel && slp_b == !sel, "R9", {slp_t, slp_b}, {2{!sel}});
    if (!sel) begin
      chk(!en_t && !en_b, "R5", {en_t, en_b}, 0);
    end else if (!w) begin
      chk(en_t, "R7", en_t, 1);
      chk(dout_t == d, "R7", dout_t, d);
      chk(!en_b, "R6", en_b, 0);
    end else begin
      chk(en_t && en_b, "R4", {en_t, en_b}, 3);
      rq = byp ? "R8" : "R4";
      if (bmem.exists(int'(ad))) begin
        chk(dout_t == bmem[int'(ad)], rq, dout_t, bmem[int'(ad)]);
        chk(dout_b == bmem[int'(ad)], rq, dout_b, bmem[int'(ad)]);
      end
    end
  endtask

  task automatic wr_we(input logic [13:0] ad, input logic [3:0] d);
    step(0, 0, 0, ad, d);
    step(0, 0, 1, ad, d);
  endtask

  task automatic expect_rd(input logic [13:0] ad, input logic [3:0] exp, input string req);
    step(0, 0, 1, ad, 4'h0);
    chk(dout_t == exp && dout_b == exp, req, dout_t, exp);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; cs_a_n = 1; cs_b_n = 1; wr_n = 1; addr = '0; din = '0;
    p_wa = 0; p_addr = '0; p_din = '0;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    chk(!en_t && !en_b, "R11", {en_t, en_b}, 0);
    chk(slp_t && slp_b, "R11", {slp_t, slp_b}, 3);
    @(negedge clk); rst = 1'b0;

    // R1: strobe-closed write, then readback
    step(0, 0, 0, 14'h1234, 4'h5);
    step(0, 0, 0, 14'h1234, 4'hA);
    step(0, 0, 1, 14'h1234, 4'h0);   // closing edge read: R8 bypass
    chk(dout_t == 4'hA, "R8", dout_t, 4'hA);
    expect_rd(14'h1234, 4'hA, "R1");

    // R2: closed by first select, then by second select
    step(0, 0, 0, 14'h0F0F, 4'h3);
    step(1, 0, 0, 14'h0F0F, 4'h3);
    expect_rd(14'h0F0F, 4'h3, "R2");
    step(0, 0, 0, 14'h3001, 4'h6);
    step(0, 1, 0, 14'h3001, 4'h6);
    expect_rd(14'h3001, 4'h6, "R2");

    // R3: strobe low with a select high writes nothing
    step(0, 1, 0, 14'h1234, 4'h1);
    step(0, 1, 1, 14'h1234, 4'h1);
    step(1, 0, 0, 14'h1234, 4'h2);
    step(1, 0, 1, 14'h1234, 4'h2);
    expect_rd(14'h1234, 4'hA, "R3");

    // R6: select and strobe rise together, blanked output stays off
    step(0, 0, 0, 14'h0042, 4'hC);
    step(1, 1, 1, 14'h0042, 4'hC);
    chk(!en_b, "R6", en_b, 0);
    expect_rd(14'h0042, 4'hC, "R2");

    // R10: single-bit neighbours are distinct words
    wr_we(14'h2A55, 4'h9);
    for (int i = 0; i < 14; i++) wr_we(14'h2A55 ^ (14'h1 << i), 4'(i));
    expect_rd(14'h2A55, 4'h9, "R10");
    for (int i = 0; i < 14; i++) expect_rd(14'h2A55 ^ (14'h1 << i), 4'(i), "R10");

    // constrained random traffic over a small address pool
    for (int i = 0; i < 8; i++) begin
      pool[i] = 14'($urandom);
      wr_we(pool[i], 4'($urandom));
    end
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
           pool[$urandom % 8], 4'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule